// File: doc/BRIEF.md
# Buffered SPI Target with Transmit and Receive Holding Registers

This block is the target (slave) side of a full-duplex SPI link that carries 8-bit words. An external controller supplies the serial clock and an active-low select line. The block brings those pins and the serial data input into the system clock domain through two-flop synchronizers and finds clock edges there. It shifts data in and out on the edges given by the clock polarity parameter. The phase is fixed: data leaves on the leading edge of each bit and is captured on the trailing edge.

The host side works like a register. A one-cycle write strobe places a byte in a transmit holding register. The byte moves into the output shifter at the first leading edge of the next word, so the host can queue the following byte while the current one is still on the wire. A receive holding register shows the most recent complete word and is released by a one-cycle read strobe. The flags transmit-empty, receive-pending and busy track the external clock, so software can keep words flowing back to back with no idle time. Underrun and overrun flags record a word sent with nothing queued and a word received while the previous one was still unread.

Top module: `spi_target_buffered`

## Requirements
- R1: After reset `txEmpty` is 1, `rxNotEmpty`, `busy`, `underrun` and `overrun` are 0, `rdData` is 0x00, and `miso` is 1 while `csN` is high.
- R2: With the serial clock idling high, the target changes `miso` after each falling edge and captures `mosi` on each rising edge, most significant bit first. The system clock runs at least four times the serial clock.
- R3: A write strobe clears `txEmpty` from the next cycle. `txEmpty` becomes 1 again when the queued byte is moved into the output shifter at the first leading edge of a word.
- R4: On the eighth capture of a word the received byte appears on `rdData` and `rxNotEmpty` is set. A read strobe clears `rxNotEmpty`. Consecutive words are presented in arrival order.
- R5: Words may follow each other with no gap while `csN` stays low. A byte queued during one word is the one sent in the next word.
- R6: `busy` rises at the first leading edge of a word. At the end of a word it stays high if a byte is queued and falls otherwise. It falls whenever `csN` is high.
- R7: If a word starts with no byte queued, the target resends the byte it sent last and sets `underrun`. The next write clears `underrun`.
- R8: If a word completes while `rxNotEmpty` is still 1 and no read strobe is present, `overrun` is set and `rdData` takes the newest byte. A read strobe clears `overrun`.
- R9: Raising `csN` in the middle of a word discards the partial word. `rxNotEmpty` keeps its value, `busy` falls, and the next word is received whole.
- R10: `miso` is driven from the shifter only while `csN` is low; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the controller |
| csN | input | 1 | Select from the controller, active low |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data out of the target |
| wrEn | input | 1 | One-cycle strobe to queue `wrData` |
| wrData | input | 8 | Byte to send |
| rdEn | input | 1 | One-cycle strobe that releases the received byte |
| rdData | output | 8 | Most recently received byte |
| txEmpty | output | 1 | Transmit holding register is free |
| rxNotEmpty | output | 1 | Unread received byte is present |
| busy | output | 1 | A word is in progress or about to follow |
| underrun | output | 1 | A word was sent with nothing queued |
| overrun | output | 1 | A word arrived before the previous one was read |

## Verification
The assertions check the local cause-and-effect rules on every cycle. A write empties nothing and fills the holding register. A load from the buffer frees it. A completed word raises `rxNotEmpty`. Deselection clears the bit count and `busy`. Underrun and overrun rise only when the buffer state justifies them. The shifter strobes are mutually exclusive. Only the bench scenarios can show that the bytes cross the link correctly in both directions across three back-to-back words, that a resent byte after an underrun is the right one, that an overrun keeps the newest byte, and that a word aborted mid-way leaves the next word intact. A behavioural model compares every flag and `miso` on every clock.

// File: rtl/spi_target_pkg.sv
package spi_target_pkg;

  // strobes from the control path to the datapath, at most one shifter action per cycle
  typedef struct packed {
    logic loadBuf;   // move the holding byte into the output shifter
    logic loadLast;  // reload the previously sent byte (nothing queued)
    logic shiftOut;  // advance the output shifter by one bit
    logic sampleIn;  // capture the synchronized serial input
    logic commitRx;  // last capture of a word: publish the received byte
    logic writeBuf;  // host writes the holding register
  } dpStrobe_t;

endpackage

// File: rtl/spi_target_ctrl.sv
module spi_target_ctrl
  import spi_target_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CPOL        = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sck,
  input  logic      csN,
  input  logic      mosi,
  input  logic      wrEn,
  input  logic      rdEn,
  output logic      mosiS,
  output dpStrobe_t strb,
  output logic      txEmpty,
  output logic      rxNotEmpty,
  output logic      busy,
  output logic      underrun,
  output logic      overrun
);

  localparam int   CNT_W    = $clog2(DATA_W);
  localparam logic IDLE_SCK = 1'(CPOL);

  logic [SYNC_STAGES-1:0] sckPipe, csPipe, mosiPipe;
  logic                   sckPrev;
  logic                   sckS, csLow;
  logic                   riseE, fallE, leadE, trailE;
  logic [CNT_W-1:0]       bitCnt;
  logic                   lastBit, frameStart;
  logic                   txFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckPipe  <= {SYNC_STAGES{IDLE_SCK}};
      csPipe   <= '1;
      mosiPipe <= '0;
      sckPrev  <= IDLE_SCK;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sck};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      sckPrev  <= sckS;
    end
  end

  assign sckS  = sckPipe[SYNC_STAGES-1];
  assign csLow = ~csPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];
  assign riseE = sckS & ~sckPrev;
  assign fallE = ~sckS & sckPrev;

  generate
    if (CPOL != 0) begin : g_idleHigh
      assign leadE  = fallE;
      assign trailE = riseE;
    end else begin : g_idleLow
      assign leadE  = riseE;
      assign trailE = fallE;
    end
  endgenerate

  assign lastBit    = (bitCnt == CNT_W'(DATA_W - 1));
  assign frameStart = csLow & leadE & (bitCnt == '0);

  always_comb begin
    strb          = '0;
    strb.loadBuf  = frameStart & txFull;
    strb.loadLast = frameStart & ~txFull;
    strb.shiftOut = csLow & leadE & (bitCnt != '0);
    strb.sampleIn = csLow & trailE;
    strb.commitRx = csLow & trailE & lastBit;
    strb.writeBuf = wrEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt     <= '0;
      txFull     <= 1'b0;
      rxNotEmpty <= 1'b0;
      busy       <= 1'b0;
      underrun   <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      txFull     <= wrEn | (txFull & ~strb.loadBuf);
      underrun   <= strb.loadLast | (underrun & ~wrEn);
      rxNotEmpty <= strb.commitRx | (rxNotEmpty & ~rdEn);
      overrun    <= (strb.commitRx & rxNotEmpty & ~rdEn) | (overrun & ~rdEn);
      if (!csLow) begin
        bitCnt <= '0;
        busy   <= 1'b0;
      end else begin
        if (strb.sampleIn) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (frameStart) busy <= 1'b1;
        else if (strb.commitRx && !txFull) busy <= 1'b0;
      end
    end
  end

  assign txEmpty = ~txFull;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !txEmpty); // R3
  AST_LOAD_FREES: assert property (@(posedge clk) disable iff (rst)
    (strb.loadBuf && !wrEn) |=> txEmpty); // R3
  AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (rst)
    strb.commitRx |=> rxNotEmpty); // R4
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !csLow |=> (bitCnt == '0 && !busy)); // R9
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(!txFull)); // R7
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rxNotEmpty)); // R8
  AST_SHIFT_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadBuf, strb.loadLast, strb.shiftOut, strb.sampleIn})); // R2

endmodule

// File: rtl/spi_target_dp.sv
module spi_target_dp
  import spi_target_pkg::*;
#(
  parameter int   DATA_W    = 8,
  parameter logic IDLE_MISO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mosiS,
  input  logic              csN,
  output logic              miso,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] txBuf, lastByte, txShift, rxShift, rxBuf, rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], mosiS};

  always_ff @(posedge clk) begin
    if (rst) begin
      txBuf    <= '0;
      lastByte <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      rxBuf    <= '0;
    end else begin
      if (strb.writeBuf) txBuf <= wrData;
      if (strb.loadBuf) begin
        txShift  <= txBuf;
        lastByte <= txBuf;
      end else if (strb.loadLast) begin
        txShift <= lastByte;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strb.sampleIn) rxShift <= rxNext;
      if (strb.commitRx) rxBuf <= rxNext;
    end
  end

  assign miso   = csN ? IDLE_MISO : txShift[DATA_W-1];
  assign rdData = rxBuf;

  AST_LOAD_RECORDS: assert property (@(posedge clk) disable iff (rst)
    (strb.loadBuf || strb.loadLast) |=> (txShift == lastByte)); // R7

endmodule

// File: rtl/spi_target_buffered.sv
module spi_target_buffered
  import spi_target_pkg::*;
#(
  parameter int   DATA_W      = 8,
  parameter int   CPOL        = 1,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_MISO   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              txEmpty,
  output logic              rxNotEmpty,
  output logic              busy,
  output logic              underrun,
  output logic              overrun
);

  dpStrobe_t strb;
  logic      mosiS;

  spi_target_ctrl #(
    .DATA_W(DATA_W), .CPOL(CPOL), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sck(sck), .csN(csN), .mosi(mosi),
    .wrEn(wrEn), .rdEn(rdEn), .mosiS(mosiS), .strb(strb),
    .txEmpty(txEmpty), .rxNotEmpty(rxNotEmpty), .busy(busy),
    .underrun(underrun), .overrun(overrun)
  );

  spi_target_dp #(
    .DATA_W(DATA_W), .IDLE_MISO(IDLE_MISO)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .mosiS(mosiS),
    .csN(csN), .miso(miso), .rdData(rdData)
  );

endmodule

// File: tb/spi_target_buffered_test.sv
module spi_target_buffered_test;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b1;
  logic       csN = 1'b1;
  logic       mosi = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic       miso, txEmpty, rxNotEmpty, busy, underrun, overrun;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_target_buffered uut (
    .clk(clk), .rst(rst), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .txEmpty(txEmpty), .rxNotEmpty(rxNotEmpty), .busy(busy),
    .underrun(underrun), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model: pin histories in queues, state in plain variables
  bit sckQ[$], csQ[$], mosiQ[$];
  bit mFull, mRxNE, mBusy, mUnd, mOvr;
  logic [7:0] mBuf, mLast, mOut, mAcc, mRxBuf;
  int mCnt;

  always @(posedge clk) begin
    bit lead, trail, sel, fs, sh, samp, commit, oldFull, oldNE;
    logic [7:0] acc;
    if (rst) begin
      sckQ = '{1, 1, 1, 1}; csQ = '{1, 1, 1, 1}; mosiQ = '{0, 0, 0, 0};
      mFull = 0; mRxNE = 0; mBusy = 0; mUnd = 0; mOvr = 0;
      mBuf = 0; mLast = 0; mOut = 0; mAcc = 0; mRxBuf = 0; mCnt = 0;
    end else begin
      sckQ.push_front(sck); csQ.push_front(csN); mosiQ.push_front(mosi);
      void'(sckQ.pop_back()); void'(csQ.pop_back()); void'(mosiQ.pop_back());
      lead   = sckQ[3] && !sckQ[2];
      trail  = !sckQ[3] && sckQ[2];
      sel    = !csQ[2];
      fs     = sel && lead && mCnt == 0;
      sh     = sel && lead && mCnt != 0;
      samp   = sel && trail;
      commit = samp && mCnt == 7;
      oldFull = mFull; oldNE = mRxNE;
      acc = {mAcc[6:0], mosiQ[2]};
      if (fs) begin
        if (oldFull) begin mOut = mBuf; mLast = mBuf; end
        else mOut = mLast;
      end else if (sh) mOut = {mOut[6:0], 1'b0};
      if (wrEn) mBuf = wrData;
      mFull = wrEn ? 1'b1 : ((fs && oldFull) ? 1'b0 : oldFull);
      mUnd  = (fs && !oldFull) ? 1'b1 : (wrEn ? 1'b0 : mUnd);
      if (samp) mAcc = acc;
      if (commit) mRxBuf = acc;
      mOvr  = (commit && oldNE && !rdEn) || (mOvr && !rdEn);
      mRxNE = commit || (oldNE && !rdEn);
      if (!sel) begin
        mCnt = 0; mBusy = 0;
      end else begin
        if (samp) mCnt = (mCnt == 7) ? 0 : mCnt + 1;
        if (fs) mBusy = 1;
        else if (commit && !oldFull) mBusy = 0;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(txEmpty == !mFull, "R3 txEmpty", txEmpty, !mFull);
      check(rxNotEmpty == mRxNE, "R4 rxNotEmpty", rxNotEmpty, mRxNE);
      check(rdData == mRxBuf, "R4 rdData", rdData, mRxBuf);
      check(busy == mBusy, "R6 busy", busy, mBusy);
      check(underrun == mUnd, "R7 underrun", underrun, mUnd);
      check(overrun == mOvr, "R8 overrun", overrun, mOvr);
      check(miso == (csN ? 1'b1 : mOut[7]), "R10 miso", miso, csN ? 1 : mOut[7]);
    end
  end

  // model controller
  logic [7:0] ctlTx[$];
  logic [7:0] ctlRx[$];

  task automatic runWords(input int n);
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int f = 0; f < n; f++) begin
      logic [7:0] b = ctlTx.pop_front();
      logic [7:0] r = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        sck = 1'b0; mosi = b[i];
        repeat (HALF) @(negedge clk);
        r = {r[6:0], miso};
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      ctlRx.push_back(r);
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic hostRead(output logic [7:0] d);
    while (!rxNotEmpty) @(negedge clk);
    d = rdData;
    rdEn = 1'b1;
    @(negedge clk) rdEn = 1'b0;
  endtask

  task automatic waitTxEmpty();
    while (!txEmpty) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WATCHDOG", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] got;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txEmpty == 1'b1, "R1 txEmpty", txEmpty, 1);
    check(rxNotEmpty == 1'b0, "R1 rxNotEmpty", rxNotEmpty, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(underrun == 1'b0 && overrun == 1'b0, "R1 error flags", {underrun, overrun}, 0);
    check(rdData == 8'h00, "R1 rdData", rdData, 0);
    check(miso == 1'b1, "R1 miso idle", miso, 1);

    // three continuous words, host streams in both directions (R2, R3, R4, R5, R6)
    hostWrite(8'hF1);
    check(txEmpty == 1'b0, "R3 write clears txEmpty", txEmpty, 0);
    ctlTx = '{8'hA1, 8'hA2, 8'hA3};
    fork
      runWords(3);
      begin
        waitTxEmpty(); hostWrite(8'hF2);
        hostRead(got); check(got == 8'hA1, "R4 first word", got, 8'hA1);
        waitTxEmpty(); hostWrite(8'hF3);
        hostRead(got); check(got == 8'hA2, "R4 second word", got, 8'hA2);
        hostRead(got); check(got == 8'hA3, "R4 third word", got, 8'hA3);
      end
    join
    check(ctlRx.size() == 3, "R5 word count", ctlRx.size(), 3);
    got = ctlRx.pop_front(); check(got == 8'hF1, "R2 first sent", got, 8'hF1);
    got = ctlRx.pop_front(); check(got == 8'hF2, "R5 second sent", got, 8'hF2);
    got = ctlRx.pop_front(); check(got == 8'hF3, "R5 third sent", got, 8'hF3);
    check(busy == 1'b0, "R6 busy after last word", busy, 0);
    check(underrun == 1'b0 && overrun == 1'b0, "R5 no error flags", {underrun, overrun}, 0);

    // underrun: nothing queued, last byte is sent again (R7)
    ctlTx = '{8'h5C};
    runWords(1);
    got = ctlRx.pop_front(); check(got == 8'hF3, "R7 resent byte", got, 8'hF3);
    check(underrun == 1'b1, "R7 underrun set", underrun, 1);
    hostRead(got); check(got == 8'h5C, "R4 word during underrun", got, 8'h5C);
    hostWrite(8'h3E);
    check(underrun == 1'b0, "R7 write clears underrun", underrun, 0);

    // overrun: two words with no read in between (R8)
    ctlTx = '{8'h11, 8'h22};
    runWords(2);
    check(overrun == 1'b1, "R8 overrun set", overrun, 1);
    check(rdData == 8'h22, "R8 newest byte kept", rdData, 8'h22);
    got = ctlRx.pop_front(); check(got == 8'h3E, "R8 queued byte sent", got, 8'h3E);
    got = ctlRx.pop_front(); check(got == 8'h3E, "R7 second word resent", got, 8'h3E);
    hostRead(got);
    check(overrun == 1'b0, "R8 read clears overrun", overrun, 0);
    check(rxNotEmpty == 1'b0, "R4 read clears rxNotEmpty", rxNotEmpty, 0);

    // abort a word part way, then a full word (R9)
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; mosi = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b1; repeat (HALF) @(negedge clk);
    end
    check(busy == 1'b1, "R6 busy mid word", busy, 1);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    check(rxNotEmpty == 1'b0, "R9 abort keeps rxNotEmpty", rxNotEmpty, 0);
    check(busy == 1'b0, "R9 abort drops busy", busy, 0);
    check(miso == 1'b1, "R10 idle after abort", miso, 1);
    ctlTx = '{8'h96};
    runWords(1);
    void'(ctlRx.pop_front());
    hostRead(got); check(got == 8'h96, "R9 word after abort", got, 8'h96);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule